// File: doc/BRIEF.md
# Row-Hit-First Request Picker for a Memory Command Queue

This block keeps a short, age-ordered list of pending memory requests, each tagged with a bank number and a row address. When the controller asks for the next request, the block chooses one entry and moves it to slot 0. The other entries keep their relative order. The choice depends on a mode input. In oldest-first mode the oldest entry is always taken. In row-hit-first mode, the oldest entry whose row is already open in its bank is taken first. If no entry hits an open row, the block takes the oldest entry whose bank is ready.

For each bank, the block sees the open row and the time at which that bank becomes free. It also sees a running time value. A bank counts as ready when its free time is not later than the current time. A bank also counts as ready when it is among the soonest-free banks that the current entries target. The controller takes requests from slot 0 with a pop strobe. The same block can be built once for the read list and once for the write list.

Top module: `frs_sel`

## Requirements
- R1: After synchronous reset the list is empty, `head_valid_o` is 0, `grant_valid_o` is 0 and `policy_err_o` is 0.
- R2: A push appends the request behind all held entries, so entries leave in arrival order when nothing reorders them. A push into a full list of DEPTH entries is dropped unless a pop takes effect in the same cycle.
- R3: A pop that takes effect removes the slot-0 entry and keeps the order of the rest. A pop on an empty list changes nothing.
- R4: When `policy_i` is 2'b00 (oldest-first), a select strobe grants index 0 and leaves the order unchanged.
- R5: When `policy_i` is 2'b01 (row-hit-first), a select strobe grants the lowest-index valid entry whose row equals the open row of its bank. Index 0 is the oldest entry, and the open row of bank b is the slice [b*ROW_W +: ROW_W] of `open_rows_i`.
- R6: In row-hit-first mode, a row hit at any index is chosen over an older entry whose bank is ready.
- R7: In row-hit-first mode with no row hit, the block grants the lowest-index entry for which one of two conditions holds. Either its bank's free time (slice [b*TIME_W +: TIME_W] of `free_at_i`) is at or below `now_i`, or that free time equals the smallest free time over the banks of all valid entries. Ties mark several banks.
- R8: One cycle after a granting select, `grant_valid_o` is 1 and `grant_idx_o` gives the original index of the chosen entry. From the same edge, the chosen entry sits in slot 0 and the entries that were ahead of it each move back one slot.
- R9: A select strobe on an empty list produces no grant.
- R10: A select strobe with `policy_i` at 2'b10 or 2'b11 makes `policy_err_o` high for one cycle. It produces no grant and does not reorder the list.
- R11: When a granting select and a pop arrive in the same cycle, the pop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Append a request |
| push_bank_i | input | BANK_W | Bank of the appended request |
| push_row_i | input | ROW_W | Row of the appended request |
| pop_i | input | 1 | Remove the slot-0 entry |
| sel_i | input | 1 | Choose the next request and move it to slot 0 |
| policy_i | input | 2 | 00 oldest-first, 01 row-hit-first, others illegal |
| now_i | input | TIME_W | Current time |
| open_rows_i | input | NBANK*ROW_W | Open row of each bank |
| free_at_i | input | NBANK*TIME_W | Time at which each bank becomes free |
| head_valid_o | output | 1 | Slot 0 holds a request |
| head_bank_o | output | BANK_W | Bank of slot 0 |
| head_row_o | output | ROW_W | Row of slot 0 |
| grant_valid_o | output | 1 | A grant was made at the previous edge |
| grant_idx_o | output | IDX_W | Original index of the granted entry |
| policy_err_o | output | 1 | Select strobe arrived with an illegal policy |

## Verification
Directed patterns test the selection rules one at a time:
- Oldest-first is run with a row hit deeper in the list, which shows that this mode ignores the open rows.
- Two hits at different depths show that the oldest hit is chosen.
- A young hit placed behind a ready old entry shows that a hit has priority.
- Lists with no hits and staggered or tied bank free times separate the ready-now rule from the soonest-free rule.

A long random phase mixes pushes, pops, selects and both legal policies. It uses narrow row and time ranges so that hits, ties and full-list pushes happen often. Each move-to-front is then checked through the order in which entries later reach slot 0.

// File: rtl/frs_pkg.sv
package frs_pkg;
  localparam logic [1:0] POL_FCFS   = 2'd0;
  localparam logic [1:0] POL_FRFCFS = 2'd1;

  function automatic logic pol_legal(input logic [1:0] p);
    return (p == POL_FCFS) || (p == POL_FRFCFS);
  endfunction
endpackage

// File: rtl/frs_store.sv
module frs_store #(
  parameter int DEPTH  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int IDX_W  = 3,
  parameter int CNT_W  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      push,
  input  logic [BANK_W-1:0]         push_bank,
  input  logic [ROW_W-1:0]          push_row,
  input  logic                      pop,
  input  logic                      move,
  input  logic [IDX_W-1:0]          move_idx,
  output logic [DEPTH-1:0]          valid_o,
  output logic [DEPTH*BANK_W-1:0]   banks_o,
  output logic [DEPTH*ROW_W-1:0]    rows_o,
  output logic [CNT_W-1:0]          count_o
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [BANK_W-1:0] bank_q [DEPTH];
  logic [ROW_W-1:0]  row_q  [DEPTH];
  logic [BANK_W-1:0] bank_n [DEPTH];
  logic [ROW_W-1:0]  row_n  [DEPTH];
  logic [CNT_W-1:0]  count_q, cnt_n;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      bank_n[i] = bank_q[i];
      row_n[i]  = row_q[i];
    end
    cnt_n = count_q;
    if (move) begin
      for (int i = 1; i < DEPTH; i++) begin
        if (i <= int'(move_idx)) begin
          bank_n[i] = bank_q[i-1];
          row_n[i]  = row_q[i-1];
        end
      end
      bank_n[0] = bank_q[move_idx];
      row_n[0]  = row_q[move_idx];
    end else if (pop && count_q != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        bank_n[i] = bank_q[i+1];
        row_n[i]  = row_q[i+1];
      end
      cnt_n = count_q - 1'b1;
    end
    if (push && cnt_n < FULL) begin
      bank_n[cnt_n[IDX_W-1:0]] = push_bank;
      row_n[cnt_n[IDX_W-1:0]]  = push_row;
      cnt_n = cnt_n + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) count_q <= '0;
    else     count_q <= cnt_n;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      bank_q[i] <= bank_n[i];
      row_q[i]  <= row_n[i];
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_out
      assign valid_o[g]                      = (count_q > CNT_W'(g));
      assign banks_o[g*BANK_W +: BANK_W]     = bank_q[g];
      assign rows_o[g*ROW_W +: ROW_W]        = row_q[g];
    end
  endgenerate
  assign count_o = count_q;

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count_q <= FULL);

  // R3
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !move && !push && count_q == '0) |=> (count_q == '0));

  // R8
  mtf_head_chk: assert property (@(posedge clk) disable iff (rst)
    move |=> (bank_q[0] == $past(bank_q[move_idx]) && row_q[0] == $past(row_q[move_idx])));

  // R8
  mtf_count_chk: assert property (@(posedge clk) disable iff (rst)
    (move && !push) |=> $stable(count_q));
endmodule

// File: rtl/frs_mask.sv
module frs_mask #(
  parameter int DEPTH  = 8,
  parameter int NBANK  = 8,
  parameter int BANK_W = 3,
  parameter int TIME_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [DEPTH-1:0]          valid,
  input  logic [DEPTH*BANK_W-1:0]   banks,
  input  logic [NBANK*TIME_W-1:0]   free_at,
  output logic [NBANK-1:0]          mask
);
  logic [NBANK-1:0]  used;
  logic [TIME_W-1:0] min_t;

  always_comb begin
    used = '0;
    for (int i = 0; i < DEPTH; i++)
      if (valid[i]) used[banks[i*BANK_W +: BANK_W]] = 1'b1;
    min_t = '1;
    for (int b = 0; b < NBANK; b++)
      if (used[b] && free_at[b*TIME_W +: TIME_W] < min_t)
        min_t = free_at[b*TIME_W +: TIME_W];
    for (int b = 0; b < NBANK; b++)
      mask[b] = used[b] && (free_at[b*TIME_W +: TIME_W] == min_t);
  end

  // R7
  mask_live_chk: assert property (@(posedge clk) disable iff (rst)
    (|valid) |-> (|mask));
endmodule

// File: rtl/frs_pick.sv
module frs_pick #(
  parameter int DEPTH  = 8,
  parameter int NBANK  = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 14,
  parameter int TIME_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                policy,
  input  logic [DEPTH-1:0]          valid,
  input  logic [DEPTH*BANK_W-1:0]   banks,
  input  logic [DEPTH*ROW_W-1:0]    rows,
  input  logic [NBANK*ROW_W-1:0]    open_rows,
  input  logic [NBANK*TIME_W-1:0]   free_at,
  input  logic [TIME_W-1:0]         now,
  input  logic [NBANK-1:0]          mask,
  output logic [IDX_W-1:0]          pick_idx
);
  import frs_pkg::*;

  logic [DEPTH-1:0]  hit, rdy;
  logic [IDX_W-1:0]  hit_idx, rdy_idx;
  logic [BANK_W-1:0] b;

  always_comb begin
    hit = '0;
    rdy = '0;
    for (int i = 0; i < DEPTH; i++) begin
      b = banks[i*BANK_W +: BANK_W];
      hit[i] = valid[i] && (open_rows[int'(b)*ROW_W +: ROW_W] == rows[i*ROW_W +: ROW_W]);
      rdy[i] = valid[i] && ((free_at[int'(b)*TIME_W +: TIME_W] <= now) || mask[b]);
    end
  end

  always_comb begin
    hit_idx = '0;
    rdy_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hit[i]) hit_idx = IDX_W'(i);
      if (rdy[i]) rdy_idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (policy != POL_FRFCFS) pick_idx = '0;
    else if (|hit)            pick_idx = hit_idx;
    else if (|rdy)            pick_idx = rdy_idx;
    else                      pick_idx = '0;
  end

  // R6
  hit_first_chk: assert property (@(posedge clk) disable iff (rst)
    (policy == POL_FRFCFS && (|hit)) |-> hit[pick_idx]);
endmodule

// File: rtl/frs_sel.sv
module frs_sel #(
  parameter int DEPTH  = 8,
  parameter int NBANK  = 8,
  parameter int ROW_W  = 14,
  parameter int TIME_W = 16,
  localparam int BANK_W = $clog2(NBANK),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push_i,
  input  logic [BANK_W-1:0]        push_bank_i,
  input  logic [ROW_W-1:0]         push_row_i,
  input  logic                     pop_i,
  input  logic                     sel_i,
  input  logic [1:0]               policy_i,
  input  logic [TIME_W-1:0]        now_i,
  input  logic [NBANK*ROW_W-1:0]   open_rows_i,
  input  logic [NBANK*TIME_W-1:0]  free_at_i,
  output logic                     head_valid_o,
  output logic [BANK_W-1:0]        head_bank_o,
  output logic [ROW_W-1:0]         head_row_o,
  output logic                     grant_valid_o,
  output logic [IDX_W-1:0]         grant_idx_o,
  output logic                     policy_err_o
);
  import frs_pkg::*;

  logic [DEPTH-1:0]        valid;
  logic [DEPTH*BANK_W-1:0] banks;
  logic [DEPTH*ROW_W-1:0]  rows;
  logic [CNT_W-1:0]        count;
  logic [NBANK-1:0]        mask;
  logic [IDX_W-1:0]        pick;
  logic                    legal, move;

  assign legal = pol_legal(policy_i);
  assign move  = sel_i && legal && (count != '0);

  frs_store #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst), .push(push_i), .push_bank(push_bank_i), .push_row(push_row_i),
    .pop(pop_i), .move(move), .move_idx(pick),
    .valid_o(valid), .banks_o(banks), .rows_o(rows), .count_o(count));

  frs_mask #(.DEPTH(DEPTH), .NBANK(NBANK), .BANK_W(BANK_W), .TIME_W(TIME_W)) u_mask (
    .clk(clk), .rst(rst), .valid(valid), .banks(banks), .free_at(free_at_i), .mask(mask));

  frs_pick #(.DEPTH(DEPTH), .NBANK(NBANK), .BANK_W(BANK_W), .ROW_W(ROW_W),
             .TIME_W(TIME_W), .IDX_W(IDX_W)) u_pick (
    .clk(clk), .rst(rst), .policy(policy_i), .valid(valid), .banks(banks), .rows(rows),
    .open_rows(open_rows_i), .free_at(free_at_i), .now(now_i), .mask(mask), .pick_idx(pick));

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid_o <= 1'b0;
      grant_idx_o   <= '0;
      policy_err_o  <= 1'b0;
    end else begin
      grant_valid_o <= move;
      if (move) grant_idx_o <= pick;
      policy_err_o  <= sel_i && !legal;
    end
  end

  assign head_valid_o = valid[0];
  assign head_bank_o  = banks[BANK_W-1:0];
  assign head_row_o   = rows[ROW_W-1:0];

  // R8
  grant_cause_chk: assert property (@(posedge clk) disable iff (rst)
    grant_valid_o |-> $past(sel_i));

  // R9
  no_grant_empty_chk: assert property (@(posedge clk) disable iff (rst)
    grant_valid_o |-> $past(head_valid_o));

  // R4
  fcfs_head_chk: assert property (@(posedge clk) disable iff (rst)
    (grant_valid_o && $past(policy_i) == POL_FCFS) |-> (grant_idx_o == '0));

  // R10
  err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    policy_err_o |-> !grant_valid_o);
endmodule

// File: tb/frs_sel_tb.sv
`timescale 1ns/1ps
module frs_sel_tb;
  localparam int DEPTH = 8, NBANK = 8, ROW_W = 14, TIME_W = 16;
  localparam int BANK_W = $clog2(NBANK), IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rst = 1'b1;
  logic push = 1'b0, pop = 1'b0, sel = 1'b0;
  logic [BANK_W-1:0] push_bank = '0;
  logic [ROW_W-1:0]  push_row = '0;
  logic [1:0]        pol = 2'd0;
  logic [TIME_W-1:0] now = '0;
  logic [ROW_W-1:0]  open_row [NBANK];
  logic [TIME_W-1:0] free_t [NBANK];
  logic [NBANK*ROW_W-1:0]  open_rows;
  logic [NBANK*TIME_W-1:0] free_at;
  logic head_valid, grant_valid, policy_err;
  logic [BANK_W-1:0] head_bank;
  logic [ROW_W-1:0]  head_row;
  logic [IDX_W-1:0]  grant_idx;

  typedef struct { logic [BANK_W-1:0] bank; logic [ROW_W-1:0] row; } ent_t;
  ent_t mq[$];
  bit   e_gv, e_err;
  int   e_gi = 0;
  int   checks = 0, errors = 0;
  bit   done = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  always_comb
    for (int b = 0; b < NBANK; b++) begin
      open_rows[b*ROW_W +: ROW_W]  = open_row[b];
      free_at[b*TIME_W +: TIME_W]  = free_t[b];
    end

  frs_sel #(.DEPTH(DEPTH), .NBANK(NBANK), .ROW_W(ROW_W), .TIME_W(TIME_W)) u_dut (
    .clk(clk), .rst(rst), .push_i(push), .push_bank_i(push_bank), .push_row_i(push_row),
    .pop_i(pop), .sel_i(sel), .policy_i(pol), .now_i(now), .open_rows_i(open_rows),
    .free_at_i(free_at), .head_valid_o(head_valid), .head_bank_o(head_bank),
    .head_row_o(head_row), .grant_valid_o(grant_valid), .grant_idx_o(grant_idx),
    .policy_err_o(policy_err));

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  function automatic int model_pick();
    int mn;
    if (pol == 2'd0) return 0;
    foreach (mq[i]) if (open_row[mq[i].bank] == mq[i].row) return i;
    mn = 1 << TIME_W;
    foreach (mq[i]) if (int'(free_t[mq[i].bank]) < mn) mn = int'(free_t[mq[i].bank]);
    foreach (mq[i])
      if (free_t[mq[i].bank] <= now || int'(free_t[mq[i].bank]) == mn) return i;
    return 0;
  endfunction

  task automatic compare();
    chk(head_valid == (mq.size() > 0), "head_valid", head_valid, mq.size() > 0);
    if (mq.size() > 0) begin
      chk(head_bank == mq[0].bank, "head_bank", head_bank, mq[0].bank);
      chk(head_row == mq[0].row, "head_row", head_row, mq[0].row);
    end
    chk(grant_valid == e_gv, "grant_valid", grant_valid, e_gv);
    if (e_gv) chk(int'(grant_idx) == e_gi, "grant_idx", grant_idx, e_gi);
    chk(policy_err == e_err, "policy_err", policy_err, e_err);
  endtask

  task automatic cyc();
    bit legal, mv;
    ent_t e;
    legal = (pol == 2'd0) || (pol == 2'd1);
    mv = sel && legal && mq.size() > 0;
    e_err = sel && !legal;
    e_gv = mv;
    if (mv) begin
      e_gi = model_pick();
      e = mq[e_gi];
      mq.delete(e_gi);
      mq.push_front(e);
    end else if (pop && mq.size() > 0) begin
      void'(mq.pop_front());
    end
    if (push && mq.size() < DEPTH) begin
      e.bank = push_bank; e.row = push_row;
      mq.push_back(e);
    end
    @(posedge clk);
    @(negedge clk);
    compare();
    push = 0; pop = 0; sel = 0;
  endtask

  task automatic do_push(int b, int r);
    push = 1; push_bank = BANK_W'(b); push_row = ROW_W'(r); cyc();
  endtask
  task automatic do_pop(); pop = 1; cyc(); endtask
  task automatic do_sel(int p); sel = 1; pol = 2'(p); cyc(); endtask
  task automatic drain(); while (mq.size() > 0) do_pop(); do_pop(); endtask
  task automatic banks_idle(int ft);
    for (int b = 0; b < NBANK; b++) begin open_row[b] = ROW_W'(1000 + b); free_t[b] = TIME_W'(ft); end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    banks_idle(0);
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    cur_req = "R1";
    e_gv = 0; e_err = 0;
    compare();
    cyc();
    // R2: append order and drop when full
    cur_req = "R2";
    for (int k = 0; k < DEPTH + 2; k++) do_push(k % NBANK, 10 + k);
    push = 1; pop = 1; push_bank = 3; push_row = 77; cyc();
    // R3: pops keep order, pop on empty
    cur_req = "R3";
    drain();
    // R4: oldest-first ignores a hit deeper in the list
    cur_req = "R4";
    now = 100; banks_idle(500);
    do_push(1, 11); do_push(2, 22); do_push(3, 33);
    open_row[3] = 33;
    do_sel(0);
    drain();
    // R5: oldest of two hits
    cur_req = "R5";
    banks_idle(500);
    do_push(0, 1); do_push(1, 2); do_push(2, 3); do_push(3, 4); do_push(4, 5);
    open_row[2] = 3; open_row[4] = 5;
    do_sel(1);
    // R8: order after move-to-front seen through pops
    cur_req = "R8";
    drain();
    // R6: young hit beats ready old entry
    cur_req = "R6";
    banks_idle(500); free_t[0] = 50;
    do_push(0, 7); do_push(1, 8); do_push(5, 9); do_push(6, 40);
    open_row[6] = 40;
    do_sel(1);
    drain();
    // R7: no hit, earliest-free bank and ready-now rules
    cur_req = "R7";
    banks_idle(900); free_t[1] = 300; free_t[2] = 300;
    do_push(0, 1); do_push(2, 2); do_push(1, 3);
    do_sel(1);
    drain();
    banks_idle(900); free_t[4] = 90; free_t[5] = 60;
    do_push(0, 1); do_push(4, 2); do_push(5, 3);
    do_sel(1);
    drain();
    // R9: select on empty
    cur_req = "R9";
    do_sel(1); do_sel(0);
    // R10: illegal policy
    cur_req = "R10";
    do_push(2, 5); do_push(3, 6);
    open_row[3] = 6;
    do_sel(2); do_sel(3);
    drain();
    // R11: select with pop ignores pop
    cur_req = "R11";
    banks_idle(500);
    do_push(1, 1); do_push(2, 2); do_push(3, 3);
    open_row[3] = 3;
    sel = 1; pop = 1; pol = 1; cyc();
    drain();
    // random mix
    cur_req = "R2 R3 R5 R6 R7 R8";
    for (int n = 0; n < 4000; n++) begin
      for (int b = 0; b < NBANK; b++) begin
        open_row[b] = ROW_W'($urandom_range(0, 3));
        free_t[b] = TIME_W'($urandom_range(0, 12));
      end
      now = TIME_W'($urandom_range(0, 12));
      push = ($urandom_range(0, 2) != 0);
      push_bank = BANK_W'($urandom_range(0, NBANK - 1));
      push_row = ROW_W'($urandom_range(0, 3));
      pop = ($urandom_range(0, 3) == 0);
      sel = ($urandom_range(0, 2) == 0);
      pol = 2'($urandom_range(0, 4) == 0 ? 0 : 1);
      cyc();
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule